// File: doc/BRIEF.md
# Multicycle Program Counter Update Unit

This unit holds the program counter of a multicycle processor and decides, on each rising clock edge, whether and with what the counter is reloaded. It adds nothing itself: the external ALU produces both the sequential address and the branch target. The unit picks one of three candidate values and gates the load. The candidates are:

- the live ALU result, which carries the address plus four during fetch;
- the registered ALU output, which holds a branch target computed during decode;
- a jump target built from the upper counter bits and the instruction's 26-bit jump field.

The load fires on an unconditional write request. It also fires on a conditional request when the ALU reports a zero result, which is how a branch-on-equal completes. The fourth select code is reserved and leaves the counter untouched. The counter output doubles as the fetch address and always stays word-aligned.

Top module: `pc_next_unit`

## Requirements
- R1: A synchronous active-low reset loads `RESET_ADDR` (default 0x00000000) into `pc` on the rising edge, regardless of every other input.
- R2: With `wr_always`=1 and `src_sel`=2'b00, `pc` takes `alu_result` on the next rising edge.
- R3: With `wr_always`=1 and `src_sel`=2'b01, `pc` takes `alu_reg` on the next rising edge.
- R4: With a load enabled and `src_sel`=2'b10, `pc` becomes {old `pc`[31:28], `jump_field`, 2'b00}.
- R5: With `wr_always`=0 and `wr_if_zero`=1, `pc` loads when `zero`=1 and holds its value when `zero`=0.
- R6: With `wr_always`=0 and `wr_if_zero`=0, `pc` holds its value whatever the data inputs are.
- R7: `src_sel`=2'b11 is reserved; `pc` holds its value even when `wr_always` or `wr_if_zero` with `zero` requests a load.
- R8: Every loaded value has bits [1:0] forced to 0, so `pc`[1:0] is always 2'b00.
- R9: `wr_always`=1 loads regardless of the `zero` flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alu_result | input | 32 | Live ALU result (sequential address) |
| alu_reg | input | 32 | Registered ALU output (branch target) |
| jump_field | input | 26 | Jump word-offset field of the instruction |
| zero | input | 1 | ALU zero flag |
| wr_always | input | 1 | Unconditional load request |
| wr_if_zero | input | 1 | Load request qualified by `zero` |
| src_sel | input | 2 | Source select: 00 ALU result, 01 registered ALU, 10 jump, 11 reserved |
| pc | output | 32 | Current program counter and fetch address |

## Verification
The counter is the only state, so a wrong load decision shows on `pc` one edge after the offending cycle. A wrong value is a changed `pc` where a hold was required, or an unchanged one where a load was required. A wrong source choice shows at the same edge as a value that matches the wrong candidate. Candidates are therefore given distinct values in every vector. Jump vectors run from counters with different upper nibbles, so a jump that drops or corrupts the retained bits shows within one cycle.

// File: rtl/pcu_pkg.sv
// Package: shared types for the program counter update unit.
// Assumes a two-bit source select; the encoding is fixed by the control FSM.
package pcu_pkg;
    typedef enum logic [1:0] {
        SRC_ALU_LIVE = 2'b00,
        SRC_ALU_REG  = 2'b01,
        SRC_JUMP     = 2'b10,
        SRC_RESERVED = 2'b11
    } pc_src_e;
endpackage

// File: rtl/pcu_src_mux.sv
// Source multiplexer: picks the candidate word address for the next counter.
// Produces only the word part (low alignment bits dropped) and flags the
// reserved select code so the load gate can suppress it.
module pcu_src_mux #(
    parameter int ADDR_W     = 32,
    parameter int JUMP_W     = 26,
    parameter int ALIGN_BITS = 2,
    localparam int WORD_W    = ADDR_W - ALIGN_BITS,
    localparam int UPPER_W   = ADDR_W - JUMP_W - ALIGN_BITS
) (
    input  logic [1:0]          src_sel,
    input  logic [ADDR_W-1:0]   alu_result,
    input  logic [ADDR_W-1:0]   alu_reg,
    input  logic [JUMP_W-1:0]   jump_field,
    input  logic [UPPER_W-1:0]  pc_upper,
    output logic [WORD_W-1:0]   next_word,
    output logic                src_ok
);
    import pcu_pkg::*;

    logic [ALIGN_BITS*2-1:0] unused_low;
    assign unused_low = {alu_result[ALIGN_BITS-1:0], alu_reg[ALIGN_BITS-1:0]};

    // Candidate selection by decoded source code.
    always_comb begin
        next_word = '0;
        src_ok    = 1'b1;
        case (pc_src_e'(src_sel))
            SRC_ALU_LIVE: next_word = alu_result[ADDR_W-1:ALIGN_BITS];
            SRC_ALU_REG:  next_word = alu_reg[ADDR_W-1:ALIGN_BITS];
            SRC_JUMP:     next_word = {pc_upper, jump_field};
            SRC_RESERVED: src_ok    = 1'b0;
            default:      src_ok    = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcu_load_gate.sv
// Load gate: merges the unconditional and zero-qualified write requests and
// blocks the load when the source code is reserved.
module pcu_load_gate (
    input  logic wr_always,
    input  logic wr_if_zero,
    input  logic zero,
    input  logic src_ok,
    output logic load
);
    // Combine the two write paths, then qualify with a valid source.
    always_comb begin
        load = (wr_always | (wr_if_zero & zero)) & src_ok;
    end
endmodule

// File: rtl/pcu_pc_reg.sv
// Counter register: holds the word-aligned program counter.
// Assumes the reset value is word-aligned; low alignment bits are stored as 0.
module pcu_pc_reg #(
    parameter int ADDR_W                   = 32,
    parameter int ALIGN_BITS               = 2,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int WORD_W                  = ADDR_W - ALIGN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] next_word,
    output logic [ADDR_W-1:0] pc
);
    logic [WORD_W-1:0] word_q;

    // Register the word address; reset wins over load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= RESET_ADDR[ADDR_W-1:ALIGN_BITS];
        else if (load)
            word_q <= next_word;
    end

    assign pc = {word_q, {ALIGN_BITS{1'b0}}};

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(word_q)); // R6
endmodule

// File: rtl/pc_next_unit.sv
// Top: program counter update unit of a multicycle processor.
// Selects among live ALU result, registered ALU output and jump target,
// gates the load by unconditional or zero-qualified requests, and holds the
// counter. Assumes the ALU computes all address arithmetic externally.
module pc_next_unit #(
    parameter int ADDR_W                   = 32,
    parameter int JUMP_W                   = 26,
    parameter int ALIGN_BITS               = 2,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int WORD_W                  = ADDR_W - ALIGN_BITS,
    localparam int UPPER_W                 = ADDR_W - JUMP_W - ALIGN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] alu_result,
    input  logic [ADDR_W-1:0] alu_reg,
    input  logic [JUMP_W-1:0] jump_field,
    input  logic              zero,
    input  logic              wr_always,
    input  logic              wr_if_zero,
    input  logic [1:0]        src_sel,
    output logic [ADDR_W-1:0] pc
);
    logic [WORD_W-1:0] next_word;
    logic              src_ok;
    logic              load;

    pcu_src_mux #(
        .ADDR_W     (ADDR_W),
        .JUMP_W     (JUMP_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_mux (
        .src_sel    (src_sel),
        .alu_result (alu_result),
        .alu_reg    (alu_reg),
        .jump_field (jump_field),
        .pc_upper   (pc[ADDR_W-1 -: UPPER_W]),
        .next_word  (next_word),
        .src_ok     (src_ok)
    );

    pcu_load_gate u_gate (
        .wr_always  (wr_always),
        .wr_if_zero (wr_if_zero),
        .zero       (zero),
        .src_ok     (src_ok),
        .load       (load)
    );

    pcu_pc_reg #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (ALIGN_BITS),
        .RESET_ADDR (RESET_ADDR)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .next_word  (next_word),
        .pc         (pc)
    );

    AST_LIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_always && src_sel == 2'b00) |=>
        pc[ADDR_W-1:ALIGN_BITS] == $past(alu_result[ADDR_W-1:ALIGN_BITS])); // R2
    AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_always && src_sel == 2'b01) |=>
        pc[ADDR_W-1:ALIGN_BITS] == $past(alu_reg[ADDR_W-1:ALIGN_BITS])); // R3
    AST_JUMP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_always && src_sel == 2'b10) |=>
        pc[ADDR_W-1 -: UPPER_W] == $past(pc[ADDR_W-1 -: UPPER_W])); // R4
    AST_COND_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_always && !zero) |=> $stable(pc)); // R5
    AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'b11) |=> $stable(pc)); // R7
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pc[ALIGN_BITS-1:0] == '0); // R8
endmodule

// File: tb/pc_next_unit_bench.sv
`timescale 1ns/100ps
module pc_next_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] alu_result = '0;
    logic [31:0] alu_reg = '0;
    logic [25:0] jump_field = '0;
    logic        zero = 1'b0;
    logic        wr_always = 1'b0;
    logic        wr_if_zero = 1'b0;
    logic [1:0]  src_sel = 2'b00;
    logic [31:0] pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pc_next_unit u_pc_next_unit (
        .clk(clk), .rst_n(rst_n), .alu_result(alu_result), .alu_reg(alu_reg),
        .jump_field(jump_field), .zero(zero), .wr_always(wr_always),
        .wr_if_zero(wr_if_zero), .src_sel(src_sel), .pc(pc)
    );

    typedef struct packed {
        logic        wa;
        logic        wc;
        logic        z;
        logic [1:0]  src;
        logic [31:0] alu;
        logic [31:0] areg;
        logic [25:0] jf;
        logic [31:0] exp;
        logic [15:0] tag;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 2'b00, 32'h0000_0004, 32'h0000_0F00, 26'h0000011, 32'h0000_0004, "R2"},
        '{1'b1, 1'b0, 1'b1, 2'b00, 32'h0000_0008, 32'h0000_0F04, 26'h0000012, 32'h0000_0008, "R2"},
        '{1'b0, 1'b0, 1'b1, 2'b00, 32'h0000_1234, 32'h0000_5678, 26'h0000013, 32'h0000_0008, "R6"},
        '{1'b0, 1'b1, 1'b1, 2'b01, 32'h0000_0044, 32'h0000_0100, 26'h0000014, 32'h0000_0100, "R5"},
        '{1'b0, 1'b1, 1'b0, 2'b01, 32'h0000_0048, 32'h0000_0200, 26'h0000015, 32'h0000_0100, "R5"},
        '{1'b1, 1'b0, 1'b0, 2'b01, 32'h0000_0050, 32'h0000_0ABC, 26'h0000016, 32'h0000_0ABC, "R3"},
        '{1'b1, 1'b0, 1'b0, 2'b00, 32'hF000_0010, 32'h0000_0300, 26'h0000017, 32'hF000_0010, "R2"},
        '{1'b1, 1'b0, 1'b0, 2'b10, 32'h0000_0060, 32'h0000_0400, 26'h0000123, 32'hF000_048C, "R4"},
        '{1'b1, 1'b0, 1'b0, 2'b10, 32'h0000_0064, 32'h0000_0500, 26'h3FFFFFF, 32'hFFFF_FFFC, "R4"},
        '{1'b1, 1'b1, 1'b1, 2'b11, 32'h0000_0040, 32'h0000_0600, 26'h0000018, 32'hFFFF_FFFC, "R7"},
        '{1'b1, 1'b0, 1'b0, 2'b00, 32'h0000_0007, 32'h0000_0700, 26'h0000019, 32'h0000_0004, "R8"},
        '{1'b1, 1'b0, 1'b0, 2'b01, 32'h0000_0070, 32'h0000_2003, 26'h000001A, 32'h0000_2000, "R9"},
        '{1'b0, 1'b1, 1'b1, 2'b10, 32'h0000_0074, 32'h0000_0800, 26'h0000001, 32'h0000_0004, "R5"},
        '{1'b0, 1'b0, 1'b1, 2'b00, 32'h0000_0099, 32'h0000_0900, 26'h000001B, 32'h0000_0004, "R6"}
    };

    task automatic check(input logic [31:0] exp, input string tag, input string what);
        checks++;
        if (pc !== exp) begin
            errors++;
            $display("FAIL %s %s: pc=%08h expected %08h", tag, what, pc, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        wr_always = v.wa; wr_if_zero = v.wc; zero = v.z; src_sel = v.src;
        alu_result = v.alu; alu_reg = v.areg; jump_field = v.jf;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: reset with a load request pending must still give the reset address.
        wr_always = 1'b1; alu_result = 32'h0000_0500;
        @(posedge clk); #1;
        check(32'h0, "R1", "reset over load");
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            apply(TBL[i]);
            check(TBL[i].exp, string'(TBL[i].tag), $sformatf("vector %0d", i));
        end

        // R8: low bits of pc stay zero after loading an odd value.
        checks++;
        if (pc[1:0] !== 2'b00) begin
            errors++;
            $display("FAIL R8 alignment: pc[1:0]=%b expected 00", pc[1:0]);
        end

        // R4: jump keeps upper nibble 0x7 from a prior load.
        apply('{1'b1, 1'b0, 1'b0, 2'b00, 32'h7ABC_0000, 32'h0, 26'h0, 32'h7ABC_0000, "R2"});
        check(32'h7ABC_0000, "R2", "load upper nibble 7");
        apply('{1'b1, 1'b0, 1'b1, 2'b10, 32'h0, 32'h0, 26'h2AAAAAA, 32'h7AAA_AAA8, "R4"});
        check(32'h7AAA_AAA8, "R4", "jump keeps upper nibble");

        // R7: reserved select with a conditional request and zero set.
        apply('{1'b0, 1'b1, 1'b1, 2'b11, 32'h0000_1000, 32'h0000_2000, 26'h1, 32'h7AAA_AAA8, "R7"});
        check(32'h7AAA_AAA8, "R7", "reserved with conditional load");

        // R1: reset from a nonzero counter.
        @(negedge clk); rst_n = 1'b0; wr_always = 1'b1; src_sel = 2'b01; alu_reg = 32'h0000_3000;
        @(posedge clk); #1;
        check(32'h0, "R1", "mid-run reset");
        @(negedge clk); rst_n = 1'b1; wr_always = 1'b0; wr_if_zero = 1'b0;
        @(posedge clk); #1;
        check(32'h0, "R6", "idle after reset");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, cycles=5000 expected fewer");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule